// File: doc/BRIEF.md
# PWM Shadow-Register Update Controller

This block sits between a software register port and a PWM waveform generator. Software writes a new set of timing and output values while a PWM cycle is running. The block holds these values in shadow registers. It moves all six buffered items into the active registers in one clock edge, and it does so only at a cycle boundary. The generator therefore never runs a cycle with a mix of old and new values.

There are two ways to hold back an update:

- **Explicit hold.** A hold bit blocks every boundary transfer until software clears it.
- **Automatic mode.** A transfer happens only when the last completed write before the boundary went to the reset-B compare register. When the automatic bit is set, it takes priority over the hold bit.

A software stop always transfers the pending set, so the restarted cycle uses the new values. A mirror bit makes the A-side active compares show the B-side values.

Top module: `pwm_shadow_upd`

## Requirements
- R1: After reset, every active output and every shadow value is zero. The hold, automatic and mirror bits are zero.
- R2: A write never reaches the outputs between boundaries. With neither hold nor automatic in force, each `cycle_end` pulse transfers all six shadow items together.
- R3: Register addresses:
  - 0/1: set-A high/low
  - 2/3: reset-A high/low
  - 4/5: set-B high/low
  - 6/7: reset-B high/low
  - 8: config byte
  - 9: mode bit in data[0]
  - 10: control (bit0 hold, bit1 automatic, bit2 mirror)

  A high-byte write only stages bits [11:8]. The low-byte write completes the 12-bit value, so a high-byte write alone leaves the shadow unchanged.
- R4: While hold is set and automatic is not in force, no `cycle_end` changes the active values.
- R5: After hold is cleared, the next `cycle_end` transfers the pending set.
- R6: With automatic in force, a `cycle_end` transfers only if the most recent completed write to a buffered register went to reset-B.
- R7: The reset-B-last flag clears on every transfer. It also clears on any later completed write to another buffered register.
- R8: A change of the automatic bit takes effect only after the next `cycle_end` or stop.
- R9: With automatic in force, the hold bit has no effect.
- R10: A `sw_stop` pulse transfers the shadow set whatever the hold and automatic state.
- R11: While mirror is set, `act_set_a` and `act_rst_a` show the active set-B and reset-B values. Writes to the A registers do not appear on these outputs while mirror is set.
- R12: When a buffered write lands in the same cycle as a transfer, the transfer carries the shadow value from before that write. The new value waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| cycle_end | input | 1 | End-of-cycle pulse from the PWM counter |
| sw_stop | input | 1 | Software stop pulse; forces a transfer |
| act_set_a | output | 12 | Active set-A compare (mirrored from set-B while mirror is set) |
| act_rst_a | output | 12 | Active reset-A compare (mirrored from reset-B while mirror is set) |
| act_set_b | output | 12 | Active set-B compare |
| act_rst_b | output | 12 | Active reset-B compare |
| act_cfg | output | 8 | Active output-configuration byte |
| act_mode | output | 1 | Active mode bit |

## Verification
The two functions that can fall in the same cycle are a buffered register write and a boundary transfer. The bench provokes this by holding `wr_en` on the reset-B low-byte address in the very cycle that `cycle_end` pulses. It then checks two things. The output just after that edge must still carry the previous reset-B value. The following boundary must deliver the new one. A second overlap is also exercised: the automatic bit changes while a reset-B write is pending. The bench judges this by whether that boundary transfers under the old mode.

// File: rtl/pwm_shadow_upd.sv
module pwm_shadow_upd #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          cycle_end,
  input  logic          sw_stop,
  output logic [CW-1:0] act_set_a,
  output logic [CW-1:0] act_rst_a,
  output logic [CW-1:0] act_set_b,
  output logic [CW-1:0] act_rst_b,
  output logic [7:0]    act_cfg,
  output logic          act_mode
);
  localparam int HW = CW - 8;

  logic [HW-1:0] hi_stage;
  logic [CW-1:0] sh_sa, sh_ra, sh_sb, sh_rb;
  logic [CW-1:0] ac_sa, ac_ra;
  logic [7:0]    sh_cfg;
  logic          sh_mode;
  logic          lock, auto_req, auto_eff, mirror, rb_last;
  logic          commit, boundary, wr_lo, wr_buf;

  assign boundary = cycle_end | sw_stop;
  assign commit   = sw_stop | (cycle_end & (auto_eff ? rb_last : ~lock));
  assign wr_lo    = wr_en & (wr_addr < 4'd8) & wr_addr[0];
  assign wr_buf   = wr_lo | (wr_en & (wr_addr == 4'd8 || wr_addr == 4'd9));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage <= '0;
      sh_sa <= '0; sh_ra <= '0; sh_sb <= '0; sh_rb <= '0;
      sh_cfg <= '0; sh_mode <= 1'b0;
      lock <= 1'b0; auto_req <= 1'b0; mirror <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0, 4'd2, 4'd4, 4'd6: hi_stage <= wr_data[HW-1:0];
        4'd1: sh_sa <= {hi_stage, wr_data};
        4'd3: sh_ra <= {hi_stage, wr_data};
        4'd5: sh_sb <= {hi_stage, wr_data};
        4'd7: sh_rb <= {hi_stage, wr_data};
        4'd8: sh_cfg <= wr_data;
        4'd9: sh_mode <= wr_data[0];
        4'd10: begin
          lock     <= wr_data[0];
          auto_req <= wr_data[1];
          mirror   <= wr_data[2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_eff <= 1'b0;
      rb_last  <= 1'b0;
    end else begin
      if (boundary) auto_eff <= auto_req;
      if (wr_buf) rb_last <= (wr_addr == 4'd7);
      else if (commit) rb_last <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_sa <= '0; ac_ra <= '0; act_set_b <= '0; act_rst_b <= '0;
      act_cfg <= '0; act_mode <= 1'b0;
    end else if (commit) begin
      ac_sa     <= sh_sa;
      ac_ra     <= sh_ra;
      act_set_b <= sh_sb;
      act_rst_b <= sh_rb;
      act_cfg   <= sh_cfg;
      act_mode  <= sh_mode;
    end
  end

  assign act_set_a = mirror ? act_set_b : ac_sa;
  assign act_rst_a = mirror ? act_rst_b : ac_ra;
endmodule

// File: rtl/pwm_shadow_upd_chk.sv
module pwm_shadow_upd_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cycle_end,
  input logic          sw_stop,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic [CW-1:0] act_rst_b,
  input logic [7:0]    act_cfg,
  input logic          act_mode,
  input logic [CW-1:0] sh_rb,
  input logic [7:0]    sh_cfg,
  input logic          lock,
  input logic          auto_eff,
  input logic          rb_last,
  input logic          commit
);
  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cycle_end || sw_stop) |=> ($stable(act_cfg) && $stable(act_mode) && $stable(act_rst_b)));

  assert_plain_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !lock && !auto_eff) |=> (act_cfg == $past(sh_cfg)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !sw_stop && lock && !auto_eff) |=> $stable(act_cfg));

  assert_auto_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !sw_stop && auto_eff && !rb_last) |=> ($stable(act_cfg) && $stable(act_rst_b)));

  assert_auto_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && auto_eff && rb_last) |=> (act_rst_b == $past(sh_rb)));

  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> (act_rst_b == $past(sh_rb) && act_cfg == $past(sh_cfg)));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(wr_en && wr_addr == 4'd7)) |=> !rb_last);
endmodule

bind pwm_shadow_upd pwm_shadow_upd_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .sw_stop(sw_stop),
  .wr_en(wr_en), .wr_addr(wr_addr), .act_rst_b(act_rst_b),
  .act_cfg(act_cfg), .act_mode(act_mode), .sh_rb(sh_rb), .sh_cfg(sh_cfg),
  .lock(lock), .auto_eff(auto_eff), .rb_last(rb_last), .commit(commit)
);

// File: tb/pwm_shadow_upd_test.sv
`timescale 1ns/1ps
module pwm_shadow_upd_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cycle_end = 1'b0, sw_stop = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [11:0] act_set_a, act_rst_a, act_set_b, act_rst_b;
  logic [7:0] act_cfg;
  logic act_mode;

  typedef struct {
    string req;
    logic [11:0] sa, ra, sb, rb;
    logic [7:0] cfg;
    logic mode;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_shadow_upd uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cycle_end(cycle_end), .sw_stop(sw_stop),
    .act_set_a(act_set_a), .act_rst_a(act_rst_a), .act_set_b(act_set_b),
    .act_rst_b(act_rst_b), .act_cfg(act_cfg), .act_mode(act_mode)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (act_set_a !== e.sa || act_rst_a !== e.ra || act_set_b !== e.sb ||
          act_rst_b !== e.rb || act_cfg !== e.cfg || act_mode !== e.mode) begin
        mismatched++;
        $display("FAIL %s: got sa=%h ra=%h sb=%h rb=%h cfg=%h mode=%b exp sa=%h ra=%h sb=%h rb=%h cfg=%h mode=%b",
          e.req, act_set_a, act_rst_a, act_set_b, act_rst_b, act_cfg, act_mode,
          e.sa, e.ra, e.sb, e.rb, e.cfg, e.mode);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr12(input logic [3:0] base, input logic [11:0] v);
    wr(base, {4'h0, v[11:8]});
    wr(base + 4'd1, v[7:0]);
  endtask

  task automatic endc();
    cycle_end = 1'b1;
    @(posedge clk); #1;
    cycle_end = 1'b0;
  endtask

  task automatic stopc();
    sw_stop = 1'b1;
    @(posedge clk); #1;
    sw_stop = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [11:0] sa, input logic [11:0] ra,
                            input logic [11:0] sb, input logic [11:0] rb,
                            input logic [7:0] cfg, input logic mode);
    exp_t e;
    e.req = req; e.sa = sa; e.ra = ra; e.sb = sb; e.rb = rb; e.cfg = cfg; e.mode = mode;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    expect_out("R1 reset", 0, 0, 0, 0, 0, 0);

    wr12(0, 12'h123); wr12(2, 12'h456); wr12(4, 12'h789); wr12(6, 12'hABC);
    wr(8, 8'h5A); wr(9, 8'h01);
    expect_out("R2 no early update", 0, 0, 0, 0, 0, 0);
    endc();
    expect_out("R2 commit all", 12'h123, 12'h456, 12'h789, 12'hABC, 8'h5A, 1);

    wr(10, 8'h01);
    wr12(0, 12'h111);
    endc();
    expect_out("R4 hold", 12'h123, 12'h456, 12'h789, 12'hABC, 8'h5A, 1);
    endc();
    expect_out("R4 hold again", 12'h123, 12'h456, 12'h789, 12'hABC, 8'h5A, 1);
    wr(10, 8'h00);
    expect_out("R5 waits for boundary", 12'h123, 12'h456, 12'h789, 12'hABC, 8'h5A, 1);
    endc();
    expect_out("R5 release commit", 12'h111, 12'h456, 12'h789, 12'hABC, 8'h5A, 1);

    wr(0, 8'h0F);
    endc();
    expect_out("R3 high byte alone", 12'h111, 12'h456, 12'h789, 12'hABC, 8'h5A, 1);
    wr(1, 8'h22);
    endc();
    expect_out("R3 low completes", 12'hF22, 12'h456, 12'h789, 12'hABC, 8'h5A, 1);

    wr(10, 8'h02);
    wr(8, 8'h11);
    endc();
    expect_out("R8 auto not yet in force", 12'hF22, 12'h456, 12'h789, 12'hABC, 8'h11, 1);
    wr(8, 8'h22);
    endc();
    expect_out("R6 no rb write", 12'hF22, 12'h456, 12'h789, 12'hABC, 8'h11, 1);
    wr12(6, 12'h321);
    endc();
    expect_out("R6 rb last commit", 12'hF22, 12'h456, 12'h789, 12'h321, 8'h22, 1);
    wr12(6, 12'h333); wr(8, 8'h44);
    endc();
    expect_out("R7 later write clears flag", 12'hF22, 12'h456, 12'h789, 12'h321, 8'h22, 1);
    wr12(6, 12'h355);
    endc();
    expect_out("R6 commit", 12'hF22, 12'h456, 12'h789, 12'h355, 8'h44, 1);
    wr(8, 8'h66);
    endc();
    expect_out("R7 flag cleared by commit", 12'hF22, 12'h456, 12'h789, 12'h355, 8'h44, 1);

    wr(10, 8'h03);
    wr12(6, 12'h400);
    endc();
    expect_out("R9 auto over hold", 12'hF22, 12'h456, 12'h789, 12'h400, 8'h66, 1);

    wr(10, 8'h01);
    wr12(6, 12'h410);
    endc();
    expect_out("R8 auto still in force", 12'hF22, 12'h456, 12'h789, 12'h410, 8'h66, 1);
    wr12(6, 12'h420);
    endc();
    expect_out("R8 hold now in force", 12'hF22, 12'h456, 12'h789, 12'h410, 8'h66, 1);

    stopc();
    expect_out("R10 stop commits", 12'hF22, 12'h456, 12'h789, 12'h420, 8'h66, 1);
    wr(10, 8'h00);

    wr(10, 8'h04);
    expect_out("R11 mirror", 12'h789, 12'h420, 12'h789, 12'h420, 8'h66, 1);
    wr12(0, 12'h999);
    endc();
    expect_out("R11 A write hidden", 12'h789, 12'h420, 12'h789, 12'h420, 8'h66, 1);
    wr(10, 8'h00);
    expect_out("R11 mirror off", 12'h999, 12'h456, 12'h789, 12'h420, 8'h66, 1);

    wr(6, 8'h05);
    wr_en = 1'b1; wr_addr = 4'd7; wr_data = 8'h00; cycle_end = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; cycle_end = 1'b0;
    expect_out("R12 collision keeps old", 12'h999, 12'h456, 12'h789, 12'h420, 8'h66, 1);
    endc();
    expect_out("R12 new value next", 12'h999, 12'h456, 12'h789, 12'h500, 8'h66, 1);

    @(posedge clk); #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule